// File: doc/BRIEF.md
# DDR SDRAM Command Timing Checker

This block is a synthesizable protocol monitor for a four-bank DDR SDRAM command bus. Once per clock it looks at already decoded command strobes (activate, read, write, precharge, burst terminate, DLL reset), the bank select and the bank's address bit 10. It keeps open, closed and auto-precharge state for every bank, along with elapsed-cycle counters. When a command breaks a bank timing rule or a sequencing rule, it records that fact.

Every rule owns one sticky bit in an error vector. The bit stays set until a synchronous clear arrives. A separate one-cycle violation pulse marks the clock after any offending command. All timing limits are parameters given in clock cycles, and the burst length and CAS latency are fixed at build time. The block does no data checking.

Address bit 10, carried on `pre_flag`, plays two roles:
- On a read or write it requests auto-precharge.
- On a precharge it selects all banks instead of only the addressed bank.

In every rule below, "k cycles after" means the later command is sampled k clock edges after the earlier one.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: After reset, `err` and `viol` are zero. While `clr` is high at a clock edge, `err` becomes zero on that edge, and clear takes priority over any new violation sampled in the same cycle.
- R2: A read or write to an open bank issued k < T_RCD (default 3) cycles after that bank's activate sets `err[0]`. A read with `pre_flag` high is instead held to k < T_RAP (default 2).
- R3: A precharge closes every bank when `pre_flag` is high, and only the bank on `bank` when it is low. Closing an open bank k < T_RAS (default 6) cycles after its activate sets `err[1]`.
- R4: Closing an open bank with a precharge k < T_WR (default 3) cycles after the last write accepted by that bank sets `err[2]`.
- R5: A read or write to a closed bank sets `err[3]` and is otherwise ignored. It starts no read-data window, no write-data window, no auto-precharge and no write-recovery timing.
- R6: A burst terminate sets `err[4]` in either of two cases:
  - it comes 1 to 1+BURST/2 (default 3) cycles after an accepted write, with no accepted read in between;
  - any bank has a read auto-precharge pending.
- R7: An accepted read with `pre_flag` high at cycle t leaves its bank pending through cycle t+BURST/2. An accepted write with `pre_flag` high leaves it pending through t+1+BURST/2+T_WR. The bank is closed from the next cycle on.
- R8: A read or write to a bank with auto-precharge pending sets `err[5]`. If the new command has `pre_flag` low, the pending precharge is cancelled and the bank stays open. If `pre_flag` is high, the pending window restarts from the new command.
- R9: A read issued k < T_DLL (default 200) cycles after a DLL-reset command sets `err[6]`.
- R10: A write issued 1 to CAS_LAT+BURST/2 (default 4) cycles after an accepted read sets `err[7]`.
- R11: A read or write while `init_done` is low sets `err[8]`. `viol` is high for exactly the cycle after a command that broke any rule, and every `err` bit stays set until `clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all error bits |
| init_done | input | 1 | High once the memory initialization sequence is complete |
| cmd_act | input | 1 | Activate command strobe |
| cmd_rd | input | 1 | Read command strobe |
| cmd_wr | input | 1 | Write command strobe |
| cmd_pre | input | 1 | Precharge command strobe |
| cmd_bst | input | 1 | Burst-terminate command strobe |
| cmd_dll | input | 1 | DLL-reset command strobe |
| bank | input | BANK_W | Bank address of the command |
| pre_flag | input | 1 | Address bit 10: auto-precharge on read/write, all banks on precharge |
| err | output | 9 | Sticky per-rule error bits (bit map in the requirements) |
| viol | output | 1 | One-cycle pulse after any violating command |

## Verification
Directed sequences place each command exactly on the boundary cycle of its limit and one cycle past it. This separates an off-by-one counter from a correct one for tRCD against tRAP, tRAS, tWR, the read-to-write window and the DLL wait.

Paired precharges with bit 10 high and low show whether all banks or a single bank closes. An auto-precharge followed by a same-bank access, with bit 10 low and then with it high, shows cancellation versus expiry of the pending window.

A long constrained-random stream then mixes all six commands across banks with occasional clears and initialization drops. A reference model built from cycle stamps is compared with the error vector and the pulse on every cycle, which exposes interactions between rules that the directed cases do not reach.

// File: rtl/ddr_cmd_monitor.sv
module ddr_cmd_monitor #(
  parameter int BANK_W  = 2,
  parameter int BURST   = 4,
  parameter int CAS_LAT = 2,
  parameter int T_RCD   = 3,
  parameter int T_RAP   = 2,
  parameter int T_RAS   = 6,
  parameter int T_WR    = 3,
  parameter int T_DLL   = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              init_done,
  input  logic              cmd_act,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_pre,
  input  logic              cmd_bst,
  input  logic              cmd_dll,
  input  logic [BANK_W-1:0] bank,
  input  logic              pre_flag,
  output logic [8:0]        err,
  output logic              viol
);
  localparam int NB      = 1 << BANK_W;
  localparam int RD_SPAN = CAS_LAT + BURST / 2;
  localparam int WR_SPAN = 1 + BURST / 2;
  localparam int P_RD    = BURST / 2;
  localparam int P_WR    = 1 + BURST / 2 + T_WR;
  localparam int M1      = (T_DLL > T_RAS) ? T_DLL : T_RAS;
  localparam int M2      = (M1 > P_WR) ? M1 : P_WR;
  localparam int M3      = (M2 > RD_SPAN) ? M2 : RD_SPAN;
  localparam int M4      = (M3 > T_RCD) ? M3 : T_RCD;
  localparam int MAXT    = (M4 > T_RAP) ? M4 : T_RAP;
  localparam int CW      = $clog2(MAXT + 1);

  localparam logic [CW-1:0] SAT     = '1;
  localparam logic [CW-1:0] ONE     = CW'(1);
  localparam logic [CW-1:0] K_RCD   = CW'(T_RCD);
  localparam logic [CW-1:0] K_RAP   = CW'(T_RAP);
  localparam logic [CW-1:0] K_RAS   = CW'(T_RAS);
  localparam logic [CW-1:0] K_WR    = CW'(T_WR);
  localparam logic [CW-1:0] K_DLL   = CW'(T_DLL);
  localparam logic [CW-1:0] K_RSPAN = CW'(RD_SPAN);
  localparam logic [CW-1:0] K_WSPAN = CW'(WR_SPAN);
  localparam logic [CW-1:0] K_PRD   = CW'(P_RD - 1);
  localparam logic [CW-1:0] K_PWR   = CW'(P_WR - 1);

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
    return (v == SAT) ? v : v + ONE;
  endfunction

  logic [NB-1:0]         bank_open, ap_pend, ap_rd, sel, pre_mask, ras_short, wr_short;
  logic [NB-1:0][CW-1:0] t_act, t_wr;
  logic [CW-1:0]         rd_busy, wr_busy, dll_cnt;
  logic [8:0]            hit;
  logic                  rw, sel_open;

  assign rw       = cmd_rd | cmd_wr;
  assign sel      = {{(NB-1){1'b0}}, 1'b1} << bank;
  assign pre_mask = pre_flag ? '1 : sel;
  assign sel_open = bank_open[bank];

  assign hit[0] = rw & sel_open & (t_act[bank] < ((cmd_rd & pre_flag) ? K_RAP : K_RCD));
  assign hit[1] = cmd_pre & |(pre_mask & bank_open & ras_short);
  assign hit[2] = cmd_pre & |(pre_mask & bank_open & wr_short);
  assign hit[3] = rw & ~sel_open;
  assign hit[4] = cmd_bst & ((wr_busy != '0) | |(ap_pend & ap_rd));
  assign hit[5] = rw & ap_pend[bank];
  assign hit[6] = cmd_rd & (dll_cnt < K_DLL);
  assign hit[7] = cmd_wr & (rd_busy != '0);
  assign hit[8] = rw & ~init_done;

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic          open_q, pend_q, rdk_q;
    logic [CW-1:0] act_q, wr_q, cnt_q;

    assign bank_open[i] = open_q;
    assign ap_pend[i]   = pend_q;
    assign ap_rd[i]     = rdk_q;
    assign t_act[i]     = act_q;
    assign t_wr[i]      = wr_q;
    assign ras_short[i] = act_q < K_RAS;
    assign wr_short[i]  = wr_q < K_WR;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        pend_q <= 1'b0;
        rdk_q  <= 1'b0;
        act_q  <= SAT;
        wr_q   <= SAT;
        cnt_q  <= '0;
      end else begin
        act_q <= (cmd_act & sel[i]) ? ONE : sat_inc(act_q);
        wr_q  <= (cmd_wr & sel[i] & open_q) ? ONE : sat_inc(wr_q);
        if (cmd_act & sel[i]) begin
          open_q <= 1'b1;
          pend_q <= 1'b0;
        end else if (cmd_pre & pre_mask[i]) begin
          open_q <= 1'b0;
          pend_q <= 1'b0;
        end else if (rw & sel[i] & open_q) begin
          pend_q <= pre_flag;
          rdk_q  <= cmd_rd;
          cnt_q  <= cmd_rd ? K_PRD : K_PWR;
        end else if (pend_q) begin
          if (cnt_q == '0) begin
            pend_q <= 1'b0;
            open_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_busy <= '0;
      wr_busy <= '0;
      dll_cnt <= SAT;
      err     <= '0;
      viol    <= 1'b0;
    end else begin
      rd_busy <= (cmd_rd & sel_open) ? K_RSPAN : (rd_busy != '0) ? rd_busy - ONE : rd_busy;
      wr_busy <= (cmd_wr & sel_open) ? K_WSPAN :
                 (cmd_rd & sel_open) ? '0 :
                 (wr_busy != '0) ? wr_busy - ONE : wr_busy;
      dll_cnt <= cmd_dll ? ONE : sat_inc(dll_cnt);
      err     <= clr ? '0 : (err | hit);
      viol    <= |hit;
    end
  end
endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
module ddr_cmd_monitor_chk #(
  parameter int BANK_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clr,
  input logic                   init_done,
  input logic                   cmd_rd,
  input logic                   cmd_wr,
  input logic [BANK_W-1:0]      bank,
  input logic [(1<<BANK_W)-1:0] bank_open,
  input logic [8:0]             err,
  input logic                   viol
);
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> err == '0);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((err & $past(err)) == $past(err)));

  p_pulse_has_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    viol && !$past(clr) |-> err != '0);

  p_closed_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr) && !bank_open[bank] && !clr |=> err[3]);

  p_no_init_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr) && !init_done |=> viol);
endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .init_done(init_done),
  .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .bank(bank),
  .bank_open(bank_open), .err(err), .viol(viol)
);

// File: tb/ddr_cmd_monitor_bench.sv
`timescale 1ns/1ps
module ddr_cmd_monitor_bench;
  logic clk = 0, rst_n = 0, clr = 0, init_done = 0;
  logic cmd_act = 0, cmd_rd = 0, cmd_wr = 0, cmd_pre = 0, cmd_bst = 0, cmd_dll = 0;
  logic [1:0] bank = 0;
  logic pre_flag = 0;
  logic [8:0] err;
  logic viol;

  always #10 clk = ~clk;

  ddr_cmd_monitor u_ddr_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .clr(clr), .init_done(init_done),
    .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_pre(cmd_pre),
    .cmd_bst(cmd_bst), .cmd_dll(cmd_dll), .bank(bank), .pre_flag(pre_flag),
    .err(err), .viol(viol)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit m_open[4], m_pend[4], m_aprd[4];
  int m_act[4], m_wr[4], m_apend[4];
  int m_rd = -1000, m_wb = -1000, m_dll = -100000;
  logic [8:0] x_err = '0;
  bit x_viol = 0;

  function automatic string req_of(int i);
    case (i)
      0: return "R2";  1: return "R3";  2: return "R4";
      3: return "R5";  4: return "R6";  5: return "R8";
      6: return "R9";  7: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bit_is(int i, bit e, string tag);
    chk(err[i] == e, tag, int'(err[i]), int'(e));
  endtask

  // c: 0 nop, 1 act, 2 read, 3 write, 4 precharge, 5 burst stop, 6 DLL reset
  task automatic step(int c, int b, bit f);
    logic [8:0] h = '0;
    logic [8:0] d;
    string tg = "R11";
    bit rd = (c == 2), wr = (c == 3);
    cmd_act = (c == 1); cmd_rd = rd; cmd_wr = wr;
    cmd_pre = (c == 4); cmd_bst = (c == 5); cmd_dll = (c == 6);
    bank = 2'(b); pre_flag = f;
    for (int i = 0; i < 4; i++)
      if (m_pend[i] && cyc > m_apend[i]) begin m_open[i] = 0; m_pend[i] = 0; end
    if (rd || wr) begin
      if (!init_done) h[8] = 1;
      if (!m_open[b]) h[3] = 1;
      else if (cyc - m_act[b] < ((rd && f) ? 2 : 3)) h[0] = 1;
      if (m_pend[b]) h[5] = 1;
      if (rd && cyc - m_dll < 200) h[6] = 1;
      if (wr && cyc - m_rd <= 4) h[7] = 1;
    end
    if (c == 4)
      for (int i = 0; i < 4; i++)
        if ((f || i == b) && m_open[i]) begin
          if (cyc - m_act[i] < 6) h[1] = 1;
          if (cyc - m_wr[i] < 3) h[2] = 1;
        end
    if (c == 5) begin
      if (cyc - m_wb <= 3) h[4] = 1;
      for (int i = 0; i < 4; i++) if (m_pend[i] && m_aprd[i]) h[4] = 1;
    end
    x_viol = |h;
    x_err = clr ? '0 : (x_err | h);
    if (c == 1) begin m_open[b] = 1; m_pend[b] = 0; m_act[b] = cyc; end
    if (c == 4)
      for (int i = 0; i < 4; i++)
        if (f || i == b) begin m_open[i] = 0; m_pend[i] = 0; end
    if ((rd || wr) && m_open[b]) begin
      if (wr) begin m_wr[b] = cyc; m_wb = cyc; end
      else begin m_rd = cyc; m_wb = -1000; end
      m_pend[b] = f; m_aprd[b] = rd;
      if (f) m_apend[b] = cyc + (rd ? 2 : 6);
    end
    if (c == 6) m_dll = cyc;
    cyc++;
    @(negedge clk);
    d = err ^ x_err;
    for (int i = 8; i >= 0; i--) if (d[i]) tg = req_of(i);
    chk(err == x_err, tg, int'(err), int'(x_err));
    chk(viol == x_viol, "R11", int'(viol), int'(x_viol));
  endtask

  task automatic nops(int k);
    for (int i = 0; i < k; i++) step(0, 0, 0);
  endtask

  task automatic clear_step();
    clr = 1; step(0, 0, 0); clr = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_open[i] = 0; m_pend[i] = 0; m_aprd[i] = 0;
      m_act[i] = -1000; m_wr[i] = -1000; m_apend[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(err == 0, "R1", int'(err), 0);
    chk(viol == 0, "R1", int'(viol), 0);
    init_done = 1;

    // R2: tRCD and tRAP
    step(1, 0, 0); step(2, 0, 0);
    bit_is(0, 1, "R2");
    clear_step(); step(1, 1, 0); nops(1); step(2, 1, 1);
    bit_is(0, 0, "R2");
    nops(10);

    // R3: tRAS, all-bank and single-bank precharge
    clear_step(); step(1, 2, 0); step(1, 3, 0); step(4, 0, 1);
    bit_is(1, 1, "R3");
    nops(10);
    clear_step(); step(1, 0, 0); step(1, 1, 0); nops(6); step(4, 0, 0);
    bit_is(1, 0, "R3");
    step(2, 1, 0);
    bit_is(3, 0, "R3");
    nops(5); step(4, 0, 1); step(2, 1, 0);
    bit_is(3, 1, "R5");
    step(3, 1, 0);
    bit_is(7, 0, "R5");
    nops(10);

    // R4: write recovery
    clear_step(); step(1, 3, 0); nops(6); step(3, 3, 0); step(4, 3, 0);
    bit_is(2, 1, "R4");
    bit_is(1, 0, "R4");
    nops(10);

    // R6: burst terminate during write data and during read auto-precharge
    clear_step(); step(1, 0, 0); nops(3); step(3, 0, 0); step(5, 0, 0);
    bit_is(4, 1, "R6");
    nops(2); clear_step(); step(5, 0, 0);
    bit_is(4, 0, "R6");
    step(2, 0, 1); step(5, 0, 0);
    bit_is(4, 1, "R6");
    nops(10);

    // R8 and R7: interrupted auto-precharge, cancel, expiry
    clear_step(); step(1, 1, 0); nops(3); step(3, 1, 1); step(3, 1, 0);
    bit_is(5, 1, "R8");
    nops(8); step(2, 1, 0);
    bit_is(3, 0, "R8");
    nops(5); clear_step(); step(2, 1, 1); nops(2); step(2, 1, 0);
    bit_is(3, 1, "R7");
    bit_is(5, 0, "R7");
    nops(10);

    // R9: read after DLL reset
    clear_step(); step(6, 0, 0); step(1, 2, 0); nops(3); step(2, 2, 0);
    bit_is(6, 1, "R9");
    nops(200); clear_step(); step(2, 2, 0);
    bit_is(6, 0, "R9");
    nops(10);

    // R10: read-to-write spacing
    clear_step(); step(1, 0, 0); nops(4); step(2, 0, 0); nops(3); step(3, 0, 0);
    bit_is(7, 1, "R10");
    nops(6); clear_step(); step(2, 0, 0); nops(4); step(3, 0, 0);
    bit_is(7, 0, "R10");
    nops(10);

    // R11 and R1: init gating, pulse width, stickiness, clear priority
    clear_step(); init_done = 0; step(2, 0, 0);
    bit_is(8, 1, "R11");
    chk(viol == 1, "R11", int'(viol), 1);
    step(0, 0, 0);
    chk(viol == 0, "R11", int'(viol), 0);
    bit_is(8, 1, "R11");
    clr = 1; step(2, 0, 0); clr = 0;
    chk(err == 0, "R1", int'(err), 0);
    chk(viol == 1, "R1", int'(viol), 1);
    init_done = 1;
    nops(10);

    // constrained random mix
    void'($urandom(32'd4242));
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom % 200;
      int c;
      clr = ($urandom % 16) == 0;
      init_done = ($urandom % 32) != 0;
      c = (r < 80) ? 0 : (r < 110) ? 1 : (r < 140) ? 2 : (r < 170) ? 3 :
          (r < 188) ? 4 : (r < 199) ? 5 : 6;
      step(c, int'($urandom % 4), bit'($urandom % 2));
    end
    clr = 0; init_done = 1;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule